// File: doc/BRIEF.md
# Receive-Side Frame Timestamp Tagger

This block sits on the receive side of one network port, right where words leave the MAC. It only watches the receive beat stream and never stalls it. On the first beat of each frame it captures the current time of day, which is a nanosecond count kept by its own free-running time counter. It also captures the next per-port sequence number, the configured ingress path identifier, and a snapshot of the clock-quality word and the leap-second state. These captured values form one metadata record per frame.

Records leave on a valid/ready handshake toward the DMA side. Each record also reports how many clock cycles passed between the ingress capture and the acceptance of the record. Records wait in a small queue while the consumer stalls. A frame that begins while that queue is full gets no record and is counted as a drop. Software sets the time counter through a per-clock nanosecond increment and an absolute-value load strobe.

Top module: `rx_stamp_tagger`

## Requirements
- R1: After a synchronous active-high reset, `rec_valid` is 0 and `drop_count` is 0. The time counter is 0 and the first frame after reset is given sequence 0.
- R2: The time counter adds `tod_inc` nanoseconds on every clock. While `tod_load` is high, it takes `tod_load_val` instead.
- R3: A record's `rec_tod` equals the value the time counter holds on the clock edge that samples the frame's first beat. If `tod_load` is high on that same edge, `rec_tod` is `tod_load_val`.
- R4: A first beat is a beat with `rx_valid` high while no frame is open. A frame stays open until a beat with `rx_last` high. Other beats of the frame and idle cycles create no record, so a multi-beat frame yields exactly one record.
- R5: Each frame takes the current sequence value, and the counter then advances by one. A dropped frame still takes its value. The counter is SEQ_W bits wide (32 by default) and wraps from all ones to 0.
- R6: `rec_path`, `rec_quality` and `rec_leap` are copies of `cfg_path`, `clk_quality` and `leap_state` as sampled at the first beat, carried without interpretation. The quality layout is: bit 0 satellite lock, bit 1 grandmaster lock, bit 2 frequency lock, bit 3 asymmetry calibrated, bits 7..4 jitter class, upper bits free. The leap codes are 0 none, 1 pending, 2 inserted and 3 deleted.
- R7: `rec_cycles` equals the number of clock edges from the edge that samples the first beat to the edge that accepts the record. A single-beat frame whose record is accepted on the first possible edge reports 1. Each stalled cycle adds 1.
- R8: While `rec_valid` is high and `rec_ready` is low, every record field except `rec_cycles` holds steady. Records leave in frame-arrival order.
- R9: Up to FIFO_DEPTH records, including the one being presented, wait without loss while `rec_ready` is low.
- R10: A frame whose first beat arrives while FIFO_DEPTH records are waiting, and no record is accepted on that edge, produces no record and increments `drop_count`.
- R11: A frame whose first beat arrives on the same edge that a full queue's head is accepted is stored, and `drop_count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_inc | input | INC_W | Nanoseconds added to the time counter each clock |
| tod_load | input | 1 | Load strobe for the time counter |
| tod_load_val | input | TOD_W | Absolute time loaded on `tod_load` |
| rx_valid | input | 1 | Receive beat present |
| rx_last | input | 1 | Receive beat ends its frame |
| cfg_path | input | PATH_W | Ingress path identifier |
| clk_quality | input | QUAL_W | Clock-quality status word |
| leap_state | input | LEAP_W | Leap-second state code |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_tod | output | TOD_W | Ingress nanosecond timestamp |
| rec_seq | output | SEQ_W | Per-port frame sequence |
| rec_path | output | PATH_W | Captured path identifier |
| rec_quality | output | QUAL_W | Captured clock-quality word |
| rec_leap | output | LEAP_W | Captured leap state |
| rec_cycles | output | CYC_W | Ingress-to-acceptance cycle count |
| drop_count | output | DROP_W | Frames dropped on a full queue, wrapping |

## Verification
The bench builds the tagger with SEQ_W set to 4 and keeps FIFO_DEPTH at 4. A 4-bit sequence wraps after 16 frames, so the wrap from all ones back to 0 can be reached in a short run. A queue depth of 4 lets five back-to-back single-beat frames against a stalled consumer reach both the full-queue drop and the accept-while-full case. The other widths keep their defaults, so the 64-bit stamp is checked across an absolute load near the top of its range.

// File: rtl/tagger_pkg.sv
package tagger_pkg;

  localparam int TOD_BITS  = 64;
  localparam int LEAP_BITS = 8;

  typedef enum logic [LEAP_BITS-1:0] {
    LEAP_NONE   = 8'd0,
    LEAP_PEND   = 8'd1,
    LEAP_INSERT = 8'd2,
    LEAP_DELETE = 8'd3
  } leap_e;

endpackage

// File: rtl/tagger_tod.sv
module tagger_tod #(
  parameter int TOD_W = 64,
  parameter int INC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  input  logic             load,
  input  logic [TOD_W-1:0] load_val,
  output logic [TOD_W-1:0] stamp
);

  logic [TOD_W-1:0] tod_q;

  // A capture on a load edge sees the loaded value.
  assign stamp = load ? load_val : tod_q;

  always_ff @(posedge clk) begin
    if (rst) tod_q <= '0;
    else if (load) tod_q <= load_val;
    else tod_q <= tod_q + TOD_W'(inc);
  end

endmodule

// File: rtl/tagger_sof.sv
module tagger_sof #(
  parameter int SEQ_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_last,
  output logic             sof,
  output logic [SEQ_W-1:0] seq
);

  logic             open_q;
  logic [SEQ_W-1:0] seq_q;

  assign sof = rx_valid && !open_q;
  assign seq = seq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      seq_q  <= '0;
    end else begin
      if (rx_valid) open_q <= !rx_last;
      if (sof) seq_q <= seq_q + 1'b1;
    end
  end

  AST_SOF_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last) |=> (!rx_valid || sof)); // R4

endmodule

// File: rtl/tagger_fifo.sv
module tagger_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop     = rd_en && !empty;
  assign push    = wr_en && (!full || pop);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (count == CW'(DEPTH))); // R9

endmodule

// File: rtl/rx_stamp_tagger.sv
module rx_stamp_tagger import tagger_pkg::*; #(
  parameter int TOD_W      = TOD_BITS,
  parameter int INC_W      = 32,
  parameter int SEQ_W      = 32,
  parameter int CYC_W      = 32,
  parameter int PATH_W     = 16,
  parameter int QUAL_W     = 16,
  parameter int LEAP_W     = LEAP_BITS,
  parameter int FIFO_DEPTH = 4,
  parameter int DROP_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INC_W-1:0]  tod_inc,
  input  logic              tod_load,
  input  logic [TOD_W-1:0]  tod_load_val,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [PATH_W-1:0] cfg_path,
  input  logic [QUAL_W-1:0] clk_quality,
  input  logic [LEAP_W-1:0] leap_state,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [TOD_W-1:0]  rec_tod,
  output logic [SEQ_W-1:0]  rec_seq,
  output logic [PATH_W-1:0] rec_path,
  output logic [QUAL_W-1:0] rec_quality,
  output logic [LEAP_W-1:0] rec_leap,
  output logic [CYC_W-1:0]  rec_cycles,
  output logic [DROP_W-1:0] drop_count
);

  localparam int O_CYC  = 0;
  localparam int O_LEAP = O_CYC + CYC_W;
  localparam int O_QUAL = O_LEAP + LEAP_W;
  localparam int O_PATH = O_QUAL + QUAL_W;
  localparam int O_SEQ  = O_PATH + PATH_W;
  localparam int O_TOD  = O_SEQ + SEQ_W;
  localparam int ENT_W  = O_TOD + TOD_W;

  logic [TOD_W-1:0]  stamp;
  logic              sof;
  logic [SEQ_W-1:0]  seq_cur;
  logic [CYC_W-1:0]  cyc_q;
  logic [DROP_W-1:0] drop_q;
  logic [ENT_W-1:0]  wr_ent, rd_ent;
  logic              q_empty, q_full, drop_now;

  tagger_tod #(.TOD_W(TOD_W), .INC_W(INC_W)) u_tod (
    .clk(clk), .rst(rst), .inc(tod_inc), .load(tod_load),
    .load_val(tod_load_val), .stamp(stamp)
  );

  tagger_sof #(.SEQ_W(SEQ_W)) u_sof (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last),
    .sof(sof), .seq(seq_cur)
  );

  // Entry holds the capture-time cycle stamp; age is taken at the head.
  assign wr_ent = {stamp, seq_cur, cfg_path, clk_quality, leap_state, cyc_q};

  tagger_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(sof), .wr_data(wr_ent),
    .rd_en(rec_ready), .rd_data(rd_ent), .empty(q_empty), .full(q_full)
  );

  assign drop_now = sof && q_full && !rec_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      drop_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (drop_now) drop_q <= drop_q + 1'b1;
    end
  end

  assign rec_valid   = !q_empty;
  assign rec_tod     = rd_ent[O_TOD  +: TOD_W];
  assign rec_seq     = rd_ent[O_SEQ  +: SEQ_W];
  assign rec_path    = rd_ent[O_PATH +: PATH_W];
  assign rec_quality = rd_ent[O_QUAL +: QUAL_W];
  assign rec_leap    = rd_ent[O_LEAP +: LEAP_W];
  assign rec_cycles  = cyc_q - rd_ent[O_CYC +: CYC_W];
  assign drop_count  = drop_q;

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_tod) &&
      $stable(rec_seq) && $stable(rec_path) && $stable(rec_leap))); // R8

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_cycles == CYC_W'($past(rec_cycles) + 1'b1))); // R7

  AST_CYC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_cycles != '0)); // R7

  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sof && !q_full) |=> $stable(drop_q)); // R10

endmodule

// File: tb/tb_rx_stamp_tagger.sv
module tb_rx_stamp_tagger;
  import tagger_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tod_inc = 32'd1;
  logic        tod_load = 1'b0;
  logic [63:0] tod_load_val = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [15:0] cfg_path = '0, clk_quality = '0;
  logic [7:0]  leap_state = '0;
  logic        rec_valid, rec_ready = 1'b0;
  logic [63:0] rec_tod;
  logic [3:0]  rec_seq;
  logic [15:0] rec_path, rec_quality;
  logic [7:0]  rec_leap;
  logic [31:0] rec_cycles;
  logic [15:0] drop_count;

  rx_stamp_tagger #(.SEQ_W(4)) dut (
    .clk(clk), .rst(rst), .tod_inc(tod_inc), .tod_load(tod_load),
    .tod_load_val(tod_load_val), .rx_valid(rx_valid), .rx_last(rx_last),
    .cfg_path(cfg_path), .clk_quality(clk_quality), .leap_state(leap_state),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_tod(rec_tod),
    .rec_seq(rec_seq), .rec_path(rec_path), .rec_quality(rec_quality),
    .rec_leap(rec_leap), .rec_cycles(rec_cycles), .drop_count(drop_count)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Time reference built from R2, and an edge counter for R7.
  logic [63:0] m_tod;
  int cyc_tb = 0;
  always @(posedge clk) begin
    cyc_tb <= cyc_tb + 1;
    if (rst) m_tod <= '0;
    else if (tod_load) m_tod <= tod_load_val;
    else m_tod <= m_tod + 64'(tod_inc);
  end

  bit         open_tb = 0;
  logic [3:0] s_exp = '0;
  logic [63:0] q_tod[$];
  logic [3:0]  q_seq[$];
  logic [15:0] q_path[$], q_qual[$];
  logic [7:0]  q_leap[$];
  int          q_start[$];

  // field order of one stimulus row: beats, stall, inc, quality, leap, path
  localparam int VECS [6][6] = '{
    '{1, 0, 1,       16'h0001, int'(LEAP_NONE),   16'h0001},
    '{3, 2, 8,       16'h00F3, int'(LEAP_PEND),   16'h00A5},
    '{2, 5, 3,       16'hAB1F, int'(LEAP_INSERT), 16'h7FFF},
    '{1, 7, 100,     16'h000E, int'(LEAP_DELETE), 16'hFFFF},
    '{5, 0, 1000000, 16'h5A5A, int'(LEAP_NONE),   16'h1234},
    '{4, 4, 0,       16'h0000, int'(LEAP_PEND),   16'h8000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic last, input logic ld = 0,
                      input logic [63:0] ldv = '0, input logic rdy = 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_last = last;
    tod_load = ld; tod_load_val = ldv; rec_ready = rdy;
    if (!open_tb) begin
      q_tod.push_back(ld ? ldv : m_tod);
      q_seq.push_back(s_exp);
      q_path.push_back(cfg_path);
      q_qual.push_back(clk_quality);
      q_leap.push_back(leap_state);
      q_start.push_back(cyc_tb);
      s_exp = s_exp + 1'b1;
    end
    open_tb = !last;
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; tod_load = 1'b0; rec_ready = 1'b0;
  endtask

  task automatic drop_front();
    void'(q_tod.pop_front()); void'(q_seq.pop_front()); void'(q_path.pop_front());
    void'(q_qual.pop_front()); void'(q_leap.pop_front()); void'(q_start.pop_front());
  endtask

  task automatic take_next(input string tag);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; tod_load = 1'b0;
    if (q_tod.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s R8 no expected record actual=0 expected=1", tag);
    end else begin
      chk({tag, " R8 valid"}, 64'(rec_valid), 64'd1);
      chk({tag, " R2/R3 tod"}, rec_tod, q_tod[0]);
      chk({tag, " R5 seq"}, 64'(rec_seq), 64'(q_seq[0]));
      chk({tag, " R6 path"}, 64'(rec_path), 64'(q_path[0]));
      chk({tag, " R6 quality"}, 64'(rec_quality), 64'(q_qual[0]));
      chk({tag, " R6 leap"}, 64'(rec_leap), 64'(q_leap[0]));
      chk({tag, " R7 cycles"}, 64'(rec_cycles), 64'(cyc_tb - q_start[0]));
      drop_front();
    end
    rec_ready = 1'b1;
    @(posedge clk);
    #1 rec_ready = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk);
    chk({tag, " R4 no extra record"}, 64'(rec_valid), 64'd0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk("R1 valid after reset", 64'(rec_valid), 64'd0);
    chk("R1 drop after reset", 64'(drop_count), 64'd0);

    // Table walk: R1 (first seq 0), R2, R3, R4, R6, R7, R8
    for (int v = 0; v < 6; v++) begin
      tod_inc = 32'(VECS[v][2]);
      clk_quality = 16'(VECS[v][3]);
      leap_state = 8'(VECS[v][4]);
      cfg_path = 16'(VECS[v][5]);
      for (int b = 0; b < VECS[v][0]; b++) beat(b == VECS[v][0] - 1);
      for (int s = 0; s < VECS[v][1]; s++) idle();
      take_next($sformatf("R1 vec%0d", v));
      expect_empty($sformatf("vec%0d", v));
    end

    // R7: single beat, accepted at once -> 1
    tod_inc = 32'd7;
    beat(1'b1, 1'b0, '0, 1'b1);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    chk("R7 immediate cycles", 64'(rec_cycles), 64'd1);
    chk("R7 immediate valid", 64'(rec_valid), 64'd1);
    drop_front();
    @(posedge clk); #1 rec_ready = 1'b0;
    expect_empty("R7 immediate");

    // R3: load on the first-beat edge; R2: later frame counts from it
    beat(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FF00);
    idle();
    take_next("R3 load same cycle");
    repeat (3) idle();
    beat(1'b1);
    idle();
    take_next("R2 after load");

    // R9/R10: four buffered, fifth dropped but consumes a sequence value
    for (int f = 0; f < 5; f++) beat(1'b1);
    void'(q_tod.pop_back()); void'(q_seq.pop_back()); void'(q_path.pop_back());
    void'(q_qual.pop_back()); void'(q_leap.pop_back()); void'(q_start.pop_back());
    idle();
    chk("R10 drop counted", 64'(drop_count), 64'd1);
    chk("R9 queue holds", 64'(rec_valid), 64'd1);
    for (int f = 0; f < 4; f++) take_next("R9 drain");
    expect_empty("R10 dropped frame");
    beat(1'b1);
    idle();
    take_next("R5 seq after drop");

    // R11: first beat on the edge a full head leaves
    for (int f = 0; f < 4; f++) beat(1'b1);
    beat(1'b1, 1'b0, '0, 1'b1);
    drop_front();
    idle();
    chk("R11 no drop on accept", 64'(drop_count), 64'd1);
    for (int f = 0; f < 4; f++) take_next("R11 drain");
    expect_empty("R11");

    // R5: sequence wraps through all ones to 0
    for (int f = 0; f < 17; f++) begin
      beat(1'b1);
      take_next("R5 wrap");
    end

    // R1: reset mid-run clears queue, drops and sequence
    beat(1'b1);
    idle();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q_tod.delete(); q_seq.delete(); q_path.delete();
    q_qual.delete(); q_leap.delete(); q_start.delete();
    open_tb = 0; s_exp = '0;
    @(negedge clk);
    chk("R1 valid after mid reset", 64'(rec_valid), 64'd0);
    chk("R1 drop after mid reset", 64'(drop_count), 64'd0);
    beat(1'b1);
    take_next("R1 seq zero after reset");

    repeat (2) @(negedge clk);
    summary();
  end

endmodule